// File: doc/BRIEF.md
# Dual-Edge Up/Down Quadrature Timer

This block is a 16-bit event counter driven from two external pins rather than from the system clock. In external-count mode the first pin is a count input whose every level change, rising or falling, moves the counter by one. The second pin sets the direction of each step: up while it is high, down while it is low. In quadrature mode the same two pins are read as the A and B phases of an incremental encoder. A valid single-phase Gray step moves the count one place, and its direction comes from the order in which the phases change.

Both pins are brought into the system clock domain through two-flop synchronizers. Edges are found by comparing each synchronized sample with the one taken a cycle earlier. An enable freezes the count, and a synchronous load presets it. Two single-cycle pulse outputs report a wrap in either direction. The asynchronous reset is released synchronously inside the block.

Top module: `ext_updown_quad_timer`

## Requirements
- R1: While reset is active and after it is released, the count is 0 and both wrap pulses are low, as long as the pins are held low.
- R2: In external-count mode (quad_mode_i = 0), each rising edge and each falling edge of the count pin moves the count by exactly one.
- R3: In external-count mode, a count-pin edge increments when the synchronized direction pin is 1 and decrements when it is 0; a change of the direction pin alone leaves the count unchanged.
- R4: In quadrature mode (quad_mode_i = 1), the phase pair {A = count pin, B = direction pin} stepping forward through the cycle 00, 10, 11, 01, 00 adds one per step; stepping backward through that cycle subtracts one per step.
- R5: In quadrature mode, a change in which both phases toggle at once leaves the count unchanged, and the new pair becomes the reference for the next step.
- R6: While run_en_i is 0, the count holds and no wrap pulse occurs. Pin activity during that time is not counted after run_en_i returns to 1.
- R7: A load_i pulse puts load_val_i into the count one cycle later. It takes priority over a step in the same cycle and raises no wrap pulse.
- R8: ovf_o is high for exactly one cycle, in the same cycle the count goes from 0xFFFF to 0x0000.
- R9: unf_o is high for exactly one cycle, in the same cycle the count goes from 0x0000 to 0xFFFF.
- R10: A pin change driven just after a clock edge shows in the count after the third following rising clock edge and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_en_i | input | 1 | Count enable; holds the count while low |
| quad_mode_i | input | 1 | 0 = external count with direction pin, 1 = quadrature decode |
| load_i | input | 1 | Synchronous preset strobe |
| load_val_i | input | CNT_W | Preset value |
| tclk_pin_i | input | 1 | External count pin / encoder phase A (asynchronous) |
| tdir_pin_i | input | 1 | External direction pin / encoder phase B (asynchronous) |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | One-cycle pulse on an upward wrap |
| unf_o | output | 1 | One-cycle pulse on a downward wrap |

## Verification
The hardest cases to reach are a load and a decoded step landing in the same clock cycle, and the two wraps. Pins pass through three register stages before they reach the counter, so the bench times a pin change to arrive exactly on the cycle it raises load_i. It also presets the count to 0xFFFF or 0x0000 so that a single pin step produces a wrap. All sixteen quadrature phase transitions are swept from every starting phase, and a bench model based on the Gray-cycle index predicts each result.

// File: rtl/quadtmr_pkg.sv
package quadtmr_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/quadtmr_sync.sv
// Multi-stage synchronizer for a single asynchronous level.
module quadtmr_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= {STAGES{RESET_VAL}};
    end else begin
      shift_q <= shift_d;
    end
  end

  assign q_o = shift_q[STAGES-1];

endmodule

// File: rtl/quadtmr_step_dec.sv
// Turns synchronized pin samples into count steps.
module quadtmr_step_dec
  import quadtmr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  quad_mode_i,
  input  logic  pha_i,
  input  logic  phb_i,
  output step_e step_o
);

  logic pha_q, phb_q;
  logic a_chg, b_chg;
  step_e ext_step, quad_step;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pha_q <= 1'b0;
      phb_q <= 1'b0;
    end else begin
      pha_q <= pha_i;
      phb_q <= phb_i;
    end
  end

  always_comb begin
    a_chg = pha_i ^ pha_q;
    b_chg = phb_i ^ phb_q;

    // external count: every count-pin edge, direction from phase B level
    ext_step = STEP_NONE;
    if (a_chg) begin
      ext_step = phb_i ? STEP_UP : STEP_DOWN;
    end

    // quadrature: exactly one phase may move; double moves are dropped
    quad_step = STEP_NONE;
    if (a_chg ^ b_chg) begin
      if ((a_chg && (pha_i != phb_i)) || (b_chg && (pha_i == phb_i))) begin
        quad_step = STEP_UP;
      end else begin
        quad_step = STEP_DOWN;
      end
    end

    step_o = quad_mode_i ? quad_step : ext_step;
  end

endmodule

// File: rtl/quadtmr_counter.sv
// Up/down counter with enable, preset and wrap pulses.
module quadtmr_counter
  import quadtmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  step_e            step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             unf_q, unf_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = run_en_i && (step_i != STEP_NONE);
    cnt_d  = cnt_q;
    ovf_d  = 1'b0;
    unf_d  = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_en) begin
      if (step_i == STEP_UP) begin
        cnt_d = cnt_q + CNT_ONE;
        ovf_d = (cnt_q == CNT_MAX);
      end else begin
        cnt_d = cnt_q - CNT_ONE;
        unf_d = (cnt_q == '0);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

endmodule

// File: rtl/ext_updown_quad_timer.sv
module ext_updown_quad_timer
  import quadtmr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             quad_mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tclk_pin_i,
  input  logic             tdir_pin_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o,
  output logic             unf_o
);

  localparam int NUM_PINS = 2;

  logic                rst_sync_n;
  logic [NUM_PINS-1:0] pin_raw;
  logic [NUM_PINS-1:0] pin_sync;
  step_e               step;

  // asynchronous assert, synchronous release
  quadtmr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  assign pin_raw = {tdir_pin_i, tclk_pin_i};

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin_sync
    quadtmr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .d_i    (pin_raw[gi]),
      .q_o    (pin_sync[gi])
    );
  end

  quadtmr_step_dec u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .quad_mode_i (quad_mode_i),
    .pha_i       (pin_sync[0]),
    .phb_i       (pin_sync[1]),
    .step_o      (step)
  );

  quadtmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .run_en_i   (run_en_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .step_i     (step),
    .count_o    (count_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o)
  );

endmodule

// File: rtl/quadtmr_chk.sv
module quadtmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_en_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_o,
  input logic             unf_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // R6
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !load_i) |=> ($stable(count_o) && !ovf_o && !unf_o));

  // R7
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(load_val_i) && !ovf_o && !unf_o));

  // R8
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == '0 && $past(count_o) == '1));

  // R9
  unf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (count_o == '1 && $past(count_o) == '0));

  // R2
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + ONE ||
                 count_o == $past(count_o) - ONE));

  // R8
  flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_o && unf_o));

endmodule

bind ext_updown_quad_timer quadtmr_chk #(.CNT_W(CNT_W)) u_quadtmr_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_en_i   (run_en_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .count_o    (count_o),
  .ovf_o      (ovf_o),
  .unf_o      (unf_o)
);

// File: tb/tb_ext_updown_quad_timer.sv
`timescale 1ns/1ps
module tb_ext_updown_quad_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en, quad, load;
  logic [15:0] load_val;
  logic        tclk, tdir;
  logic [15:0] count;
  logic        ovf, unf;

  int n_chk = 0, n_bad = 0;
  int ovf_seen = 0, unf_seen = 0;
  logic [15:0] exp_cnt = 16'h0;
  int exp_ovf = 0, exp_unf = 0;
  logic pa = 1'b0, pb = 1'b0;

  always #5 clk = ~clk;

  ext_updown_quad_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en), .quad_mode_i(quad),
    .load_i(load), .load_val_i(load_val), .tclk_pin_i(tclk), .tdir_pin_i(tdir),
    .count_o(count), .ovf_o(ovf), .unf_o(unf)
  );

  always @(posedge clk) begin
    if (ovf) ovf_seen++;
    if (unf) unf_seen++;
  end

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Gray cycle position of phase pair: 00->0, 10->1, 11->2, 01->3
  function automatic int gpos(input logic a, input logic b);
    if (!a && !b) return 0;
    if (a && !b)  return 1;
    if (a && b)   return 2;
    return 3;
  endfunction

  task automatic model_step(input int d);
    if (d == 1) begin
      if (exp_cnt == 16'hFFFF) exp_ovf++;
      exp_cnt = exp_cnt + 16'd1;
    end else if (d == -1) begin
      if (exp_cnt == 16'h0000) exp_unf++;
      exp_cnt = exp_cnt - 16'd1;
    end
  endtask

  task automatic set_pins(input logic a, input logic b, input string req);
    int d;
    int diff;
    d = 0;
    @(negedge clk);
    tclk = a;
    tdir = b;
    if (run_en) begin
      if (!quad) begin
        if (a != pa) d = b ? 1 : -1;
      end else begin
        diff = (gpos(a, b) - gpos(pa, pb) + 4) % 4;
        if (diff == 1) d = 1;
        else if (diff == 3) d = -1;
      end
    end
    pa = a;
    pb = b;
    model_step(d);
    repeat (4) @(negedge clk);
    check(req, count, exp_cnt);
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk);
    load = 1'b1;
    load_val = v;
    @(negedge clk);
    load = 1'b0;
    exp_cnt = v;
    check("R7 load", count, v);
  endtask

  task automatic goto_phase(input int p);
    logic a, b;
    a = (p == 1) || (p == 2);
    b = (p == 2) || (p == 3);
    set_pins(a, b, "R4 quad walk");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b1; quad = 1'b0; load = 1'b0;
    load_val = 16'h0; tclk = 1'b0; tdir = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 count in reset", count, 0);
    check("R1 ovf in reset", ovf, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 count after reset", count, 0);
    check("R1 flags after reset", {ovf, unf}, 0);

    // R2/R3: external mode, up then down, both edges
    do_load(16'h0100);
    for (int i = 0; i < 12; i++) set_pins(~pa, 1'b1, "R2 R3 up both edges");
    for (int i = 0; i < 7; i++)  set_pins(~pa, 1'b0, "R2 R3 down both edges");
    set_pins(pa, 1'b1, "R3 dir alone no step");
    set_pins(pa, 1'b0, "R3 dir alone no step");
    for (int i = 0; i < 6; i++) set_pins(~pa, i[0], "R3 alternating dir");

    // R10: latency
    @(negedge clk);
    tdir = 1'b1; pb = 1'b1;
    repeat (4) @(negedge clk);
    tclk = ~pa; pa = ~pa;
    @(negedge clk);
    @(negedge clk);
    check("R10 no change after two edges", count, exp_cnt);
    @(negedge clk);
    model_step(1);
    check("R10 change after third edge", count, exp_cnt);
    repeat (3) @(negedge clk);

    // R4/R5: quadrature, exhaustive transitions from every phase
    set_pins(1'b0, 1'b0, "R2 return to 00");
    quad = 1'b1;
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        goto_phase(p);
        goto_phase(q);
      end
    end
    for (int i = 0; i < 10; i++) goto_phase((gpos(pa, pb) + 1) % 4);
    for (int i = 0; i < 14; i++) goto_phase((gpos(pa, pb) + 3) % 4);
    for (int i = 0; i < 4; i++) begin
      set_pins(~pa, ~pb, "R5 double change ignored");
      goto_phase((gpos(pa, pb) + 1) % 4);
    end

    // R8/R9: wraps in both modes
    do_load(16'hFFFF);
    goto_phase((gpos(pa, pb) + 1) % 4);
    check("R8 quad ovf count", ovf_seen, exp_ovf);
    goto_phase((gpos(pa, pb) + 3) % 4);
    check("R9 quad unf count", unf_seen, exp_unf);
    quad = 1'b0;
    do_load(16'hFFFF);
    set_pins(~pa, 1'b1, "R8 ext wrap up");
    check("R8 ext ovf count", ovf_seen, exp_ovf);
    set_pins(~pa, 1'b0, "R9 ext wrap down");
    check("R9 ext unf count", unf_seen, exp_unf);
    check("R8 total ovf", exp_ovf, 2);
    check("R9 total unf", exp_unf, 2);

    // R6: enable low holds and drops activity
    do_load(16'h0000);
    @(negedge clk);
    run_en = 1'b0;
    for (int i = 0; i < 5; i++) set_pins(~pa, 1'b0, "R6 held while disabled");
    check("R6 no unf while disabled", unf_seen, exp_unf);
    @(negedge clk);
    run_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 no late count", count, exp_cnt);
    set_pins(~pa, 1'b1, "R6 counts again");

    // R7: load collides with a step
    do_load(16'h8000);
    @(negedge clk);
    tclk = ~pa; pa = ~pa;
    tdir = 1'b1; pb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    load = 1'b1; load_val = 16'h1234;
    @(negedge clk);
    load = 1'b0;
    exp_cnt = 16'h1234;
    repeat (3) @(negedge clk);
    check("R7 load beats step", count, 16'h1234);
    do_load(16'hFFFF);
    check("R7 load no ovf", ovf_seen, exp_ovf);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule